// File: doc/BRIEF.md
# Multi-Format 120-Bit Transmit Frame Builder

This block forms one 120-bit transmit word per frame clock cycle. A serializer then shifts it onto a 4.8 Gb/s optical link, one frame every 25 ns. A two-bit format select picks one of three layouts.

- **Protected format.** A fixed header is followed by two 2-bit slow-control fields and 80 data bits. The 84 bits after the header are scrambled for DC balance. A 32-bit forward-error-correction field then fills the tail. That field is computed outside the block and is supplied on its own input.
- **Line-coded format.** The frame is twelve 10-bit 8b/10b symbols. The first symbol is always the K28.5 comma. The other eleven symbols carry 88 user bits. Running disparity is kept from symbol to symbol and from frame to frame.
- **Wide format.** The header and slow-control fields are kept. All remaining 112 bits carry raw user data, with no scrambling and no protection.

Each accepted request produces a registered frame one clock later, with a valid strobe. The scrambler state and the line-code disparity are held in registers. Each one advances only on frames of its own format.

Top module: `tx_frame_builder`

## Requirements
- R1: While `rst` is high at a clock edge, `frame_valid` and `frame_out` are cleared to zero.
- R2: Format codes: 0 is protected, 1 is line-coded, 2 is wide. A request (`req_valid` high) with code 0, 1 or 2 gives `frame_valid` high on the next cycle. A cycle without a request gives `frame_valid` low on the next cycle, and `frame_out` keeps its last value.
- R3: Format code 3 is an off code. A request with this code gives no valid frame. It leaves `frame_out`, the scrambler state and the running disparity unchanged.
- R4: In protected format, `frame_out[119:116]` is the header 4'b0101 and `frame_out[31:0]` equals `fec_in`.
- R5: In protected format, `frame_out[115:32]` is the scrambled form of {`ic_in`, `ec_in`, `data_in[79:0]`}. Bits are processed from the MSB down. Each output bit is the input bit XOR the scrambled bits sent 39 and 58 positions earlier (polynomial x^58+x^39+1), and each output bit is fed back into the history.
- R6: The 58-bit scrambler history resets to zero and carries over from one protected frame to the next. Frames of other formats do not change it.
- R7: In line-coded format, `frame_out[119:110]` is K28.5: 0011111010 when the running disparity is negative, 1100000101 when positive. Byte k (k = 0..10) is `data_in[87-8k -: 8]`. It goes to `frame_out[109-10k -: 10]` as the standard 8b/10b code, bit order abcdeifghj with `a` at the MSB, and bits EDCBA = byte[4:0], HGF = byte[7:5].
- R8: Running disparity is negative after reset. It is updated after every symbol, including the comma, and carries over into the next line-coded frame. Frames of other formats do not change it.
- R9: In wide format the frame is {4'b0101, `ic_in`, `ec_in`, `data_in[111:0]`}.
- R10: Inputs outside the chosen layout have no effect on the frame: `data_in[111:80]` in protected format, and `data_in[111:88]`, `ic_in`, `ec_in` and `fec_in` in line-coded format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock, one frame per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Build a frame from this cycle's inputs |
| fmt_sel | input | 2 | 0 protected, 1 line-coded, 2 wide, 3 off |
| ic_in | input | 2 | Internal-control slow-control bits |
| ec_in | input | 2 | External-control slow-control bits |
| data_in | input | 112 | User payload (low bits used by the narrower formats) |
| fec_in | input | 32 | Externally computed FEC field |
| frame_valid | output | 1 | Frame on `frame_out` is new this cycle |
| frame_out | output | 120 | Assembled frame, MSB first on the line |

## Verification
The hardest behaviour to reach from the ports is the 8b/10b history dependence. Inside a frame, the code for each symbol depends on the running disparity left by all earlier symbols, and by every earlier line-coded frame. This includes the alternate 3b/4b codes, which are used only for particular 5-bit values under particular disparity. The stimulus fires long runs of line-coded frames with random bytes, mixed with the other formats and the off code, so that the disparity sits in both polarities many times when those byte values arrive. Directed all-zero frames right after reset pin the comma in both polarities. Long protected runs exercise scrambler history that spans frame boundaries and off-code gaps.

// File: rtl/txfb_pkg.sv
package txfb_pkg;

  typedef enum logic [1:0] {
    FMT_PROT  = 2'd0,
    FMT_LINE  = 2'd1,
    FMT_WIDE  = 2'd2,
    FMT_OFF   = 2'd3
  } fmt_e;

  localparam logic [9:0] COMMA_NEG = 10'b0011111010;
  localparam logic [9:0] COMMA_POS = 10'b1100000101;

  // 5b/6b sub-block, negative-disparity form, bit order abcdei
  function automatic logic [5:0] sub6_neg(input logic [4:0] x);
    case (x)
      5'd0:  sub6_neg = 6'b100111;  5'd1:  sub6_neg = 6'b011101;
      5'd2:  sub6_neg = 6'b101101;  5'd3:  sub6_neg = 6'b110001;
      5'd4:  sub6_neg = 6'b110101;  5'd5:  sub6_neg = 6'b101001;
      5'd6:  sub6_neg = 6'b011001;  5'd7:  sub6_neg = 6'b111000;
      5'd8:  sub6_neg = 6'b111001;  5'd9:  sub6_neg = 6'b100101;
      5'd10: sub6_neg = 6'b010101;  5'd11: sub6_neg = 6'b110100;
      5'd12: sub6_neg = 6'b001101;  5'd13: sub6_neg = 6'b101100;
      5'd14: sub6_neg = 6'b011100;  5'd15: sub6_neg = 6'b010111;
      5'd16: sub6_neg = 6'b011011;  5'd17: sub6_neg = 6'b100011;
      5'd18: sub6_neg = 6'b010011;  5'd19: sub6_neg = 6'b110010;
      5'd20: sub6_neg = 6'b001011;  5'd21: sub6_neg = 6'b101010;
      5'd22: sub6_neg = 6'b011010;  5'd23: sub6_neg = 6'b111010;
      5'd24: sub6_neg = 6'b110011;  5'd25: sub6_neg = 6'b100110;
      5'd26: sub6_neg = 6'b010110;  5'd27: sub6_neg = 6'b110110;
      5'd28: sub6_neg = 6'b001110;  5'd29: sub6_neg = 6'b101110;
      5'd30: sub6_neg = 6'b011110;  default: sub6_neg = 6'b101011;
    endcase
  endfunction

  // 3b/4b sub-block, negative-disparity form, bit order fghj
  function automatic logic [3:0] sub4_neg(input logic [2:0] y, input logic alt);
    case (y)
      3'd0: sub4_neg = 4'b1011;
      3'd1: sub4_neg = 4'b1001;
      3'd2: sub4_neg = 4'b0101;
      3'd3: sub4_neg = 4'b1100;
      3'd4: sub4_neg = 4'b1101;
      3'd5: sub4_neg = 4'b1010;
      3'd6: sub4_neg = 4'b0110;
      default: sub4_neg = alt ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  // returns {disparity_after, abcdeifghj}; rd = 1 means positive
  function automatic logic [10:0] enc_byte(input logic [7:0] b, input logic rd);
    logic [5:0] c6;
    logic [3:0] c4;
    logic       rd_mid;
    logic       alt;
    c6 = sub6_neg(b[4:0]);
    if (rd && (($countones(c6) != 3) || (b[4:0] == 5'd7))) c6 = ~c6;
    rd_mid = rd ^ ($countones(c6) != 3);
    alt = (!rd_mid && (b[4:0] == 5'd17 || b[4:0] == 5'd18 || b[4:0] == 5'd20)) ||
          ( rd_mid && (b[4:0] == 5'd11 || b[4:0] == 5'd13 || b[4:0] == 5'd14));
    c4 = sub4_neg(b[7:5], alt);
    if (rd_mid && (($countones(c4) != 2) || (b[7:5] == 3'd3))) c4 = ~c4;
    enc_byte = {rd_mid ^ ($countones(c4) != 2), c6, c4};
  endfunction

endpackage

// File: rtl/txfb_scrambler.sv
module txfb_scrambler #(
  parameter int N   = 84,
  parameter int LEN = 58,
  parameter int TAP = 39
) (
  input  logic [N-1:0]   din,
  input  logic [LEN-1:0] hist_i,
  output logic [N-1:0]   dout,
  output logic [LEN-1:0] hist_o
);
  logic [LEN-1:0] h;
  logic           b;

  // bit-serial recurrence unrolled over the whole field, MSB first
  always_comb begin
    h    = hist_i;
    dout = '0;
    b    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      b       = din[i] ^ h[TAP-1] ^ h[LEN-1];
      dout[i] = b;
      h       = {h[LEN-2:0], b};
    end
    hist_o = h;
  end
endmodule

// File: rtl/txfb_linecoder.sv
module txfb_linecoder #(
  parameter int NBYTES = 11
) (
  input  logic [8*NBYTES-1:0]      bytes_i,
  input  logic                     rd_i,
  output logic [10*(NBYTES+1)-1:0] syms_o,
  output logic                     rd_o
);
  import txfb_pkg::*;
  localparam int SW = 10 * (NBYTES + 1);

  logic [NBYTES:0] rd_c;   // disparity entering data symbol k

  assign syms_o[SW-1 -: 10] = rd_i ? COMMA_POS : COMMA_NEG;
  assign rd_c[0]            = ~rd_i;   // comma always unbalanced

  for (genvar k = 0; k < NBYTES; k++) begin : g_sym
    logic [10:0] enc;
    assign enc                        = enc_byte(bytes_i[8*NBYTES-1-8*k -: 8], rd_c[k]);
    assign syms_o[SW-11-10*k -: 10]   = enc[9:0];
    assign rd_c[k+1]                  = enc[10];
  end

  assign rd_o = rd_c[NBYTES];
endmodule

// File: rtl/tx_frame_builder.sv
module tx_frame_builder #(
  parameter int          FRAME_W = 120,
  parameter int          DATA_W  = 112,
  parameter int          FEC_W   = 32,
  parameter int          SC_W    = 2,
  parameter int          HDR_W   = 4,
  parameter logic [3:0]  HDR     = 4'b0101,
  parameter int          SCR_LEN = 58,
  parameter int          SCR_TAP = 39
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         fmt_sel,
  input  logic [SC_W-1:0]    ic_in,
  input  logic [SC_W-1:0]    ec_in,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [FEC_W-1:0]   fec_in,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_out
);
  import txfb_pkg::*;

  localparam int PROT_D = FRAME_W - HDR_W - 2*SC_W - FEC_W;  // 80
  localparam int SCR_W  = PROT_D + 2*SC_W;                   // 84
  localparam int NBYTES = FRAME_W / 10 - 1;                  // 11

  fmt_e fmt;
  assign fmt = fmt_e'(fmt_sel);

  logic [SCR_LEN-1:0] scr_q, scr_d;
  logic [SCR_W-1:0]   scr_out;
  logic               rd_q, rd_d;
  logic [FRAME_W-1:0] line_syms;
  logic [FRAME_W-1:0] frame_d;

  txfb_scrambler #(.N(SCR_W), .LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
    .din    ({ic_in, ec_in, data_in[PROT_D-1:0]}),
    .hist_i (scr_q),
    .dout   (scr_out),
    .hist_o (scr_d)
  );

  txfb_linecoder #(.NBYTES(NBYTES)) u_line (
    .bytes_i (data_in[8*NBYTES-1:0]),
    .rd_i    (rd_q),
    .syms_o  (line_syms),
    .rd_o    (rd_d)
  );

  always_comb begin
    case (fmt)
      FMT_PROT: frame_d = {HDR, scr_out, fec_in};
      FMT_LINE: frame_d = line_syms;
      FMT_WIDE: frame_d = {HDR, ic_in, ec_in, data_in};
      default:  frame_d = frame_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      frame_out   <= '0;
      scr_q       <= '0;
      rd_q        <= 1'b0;
    end else begin
      frame_valid <= req_valid && (fmt != FMT_OFF);
      if (req_valid) begin
        frame_out <= frame_d;
        if (fmt == FMT_PROT) scr_q <= scr_d;
        if (fmt == FMT_LINE) rd_q  <= rd_d;
      end
    end
  end
endmodule

// File: rtl/tx_frame_builder_sva.sv
module tx_frame_builder_sva #(
  parameter int         FRAME_W = 120,
  parameter int         DATA_W  = 112,
  parameter int         FEC_W   = 32,
  parameter int         SC_W    = 2,
  parameter logic [3:0] HDR     = 4'b0101
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         fmt_sel,
  input logic [SC_W-1:0]    ic_in,
  input logic [SC_W-1:0]    ec_in,
  input logic [DATA_W-1:0]  data_in,
  input logic [FEC_W-1:0]   fec_in,
  input logic               frame_valid,
  input logic [FRAME_W-1:0] frame_out
);
  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fmt_sel != 2'd3) |=> frame_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!frame_valid && $stable(frame_out)));
  p_off_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fmt_sel == 2'd3) |=> (!frame_valid && $stable(frame_out)));
  p_prot_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fmt_sel == 2'd0) |=>
      (frame_out[FRAME_W-1 -: 4] == HDR && frame_out[FEC_W-1:0] == $past(fec_in)));
  p_comma_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fmt_sel == 2'd1) |=>
      (frame_out[FRAME_W-1 -: 10] == 10'b0011111010 ||
       frame_out[FRAME_W-1 -: 10] == 10'b1100000101));
  p_wide_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fmt_sel == 2'd2) |=>
      (frame_out == {HDR, $past(ic_in), $past(ec_in), $past(data_in)}));
endmodule

bind tx_frame_builder tx_frame_builder_sva #(
  .FRAME_W(FRAME_W), .DATA_W(DATA_W), .FEC_W(FEC_W), .SC_W(SC_W), .HDR(HDR)
) u_sva (.*);

// File: tb/tx_frame_builder_bench.sv
module tx_frame_builder_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [1:0]   fmt_sel = 2'd0;
  logic [1:0]   ic_in = '0, ec_in = '0;
  logic [111:0] data_in = '0;
  logic [31:0]  fec_in = '0;
  logic         frame_valid;
  logic [119:0] frame_out;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  logic [57:0]  m_hist = '0;
  logic         m_rd = 1'b0;
  logic [119:0] m_last = '0;

  logic [5:0] T6 [0:31] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101,
    6'b101001, 6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
    6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011,
    6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010, 6'b110011, 6'b100110,
    6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
  logic [3:0] T4 [0:7] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010,
    4'b0110, 4'b1110};

  tx_frame_builder u_tx_frame_builder (.*);

  always #5 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d cycles exp=done", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [119:0] act, input logic [119:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // line code model: one symbol, disparity updated in m_rd
  function automatic logic [9:0] m_sym(input logic [7:0] b);
    logic [5:0] a; logic [3:0] c; logic alt; int x;
    x = b[4:0];
    a = T6[x];
    if (m_rd && ($countones(a) != 3 || x == 7)) a = ~a;
    if ($countones(a) != 3) m_rd = ~m_rd;
    alt = m_rd ? (x == 11 || x == 13 || x == 14) : (x == 17 || x == 18 || x == 20);
    c = (b[7:5] == 3'd7 && alt) ? 4'b0111 : T4[b[7:5]];
    if (m_rd && ($countones(c) != 2 || b[7:5] == 3'd3)) c = ~c;
    if ($countones(c) != 2) m_rd = ~m_rd;
    return {a, c};
  endfunction

  function automatic logic [119:0] model(input logic [1:0] f, input logic [1:0] i,
      input logic [1:0] e, input logic [111:0] d, input logic [31:0] q);
    logic [119:0] r; logic [83:0] p; logic o;
    r = '0;
    if (f == 2'd0) begin
      p = {i, e, d[79:0]};
      for (int k = 83; k >= 0; k--) begin
        o = p[k] ^ m_hist[38] ^ m_hist[57];
        r[32+k] = o;
        m_hist = {m_hist[56:0], o};
      end
      r[119:116] = 4'b0101;
      r[31:0] = q;
    end else if (f == 2'd1) begin
      r[119:110] = m_rd ? 10'b1100000101 : 10'b0011111010;
      m_rd = ~m_rd;
      for (int k = 0; k < 11; k++) r[109-10*k -: 10] = m_sym(d[87-8*k -: 8]);
    end else if (f == 2'd2) begin
      r = {4'b0101, i, e, d};
    end else begin
      r = m_last;
    end
    return r;
  endfunction

  task automatic send(input logic [1:0] f, input logic [1:0] i, input logic [1:0] e,
      input logic [111:0] d, input logic [31:0] q, input string req);
    logic [119:0] exp;
    @(negedge clk);
    req_valid = 1'b1; fmt_sel = f; ic_in = i; ec_in = e; data_in = d; fec_in = q;
    exp = model(f, i, e, d, q);
    @(negedge clk);
    req_valid = 1'b0;
    chk(frame_valid == (f != 2'd3), {req, " valid"}, {119'd0, frame_valid}, {119'd0, f != 2'd3});
    chk(frame_out == exp, req, frame_out, exp);
    m_last = exp;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_hist = '0; m_rd = 1'b0; m_last = '0;
  endtask

  function automatic logic [111:0] rnd112();
    return {$urandom(), $urandom(), $urandom(), 16'($urandom())};
  endfunction

  initial begin
    logic [1:0] f;
    void'($urandom(32'd20240508));
    repeat (2) @(negedge clk);
    chk(frame_valid == 1'b0 && frame_out == '0, "R1 reset state", frame_out, '0);
    rst = 1'b0;

    // R7/R8: all-zero bytes right after reset, negative then positive comma
    send(2'd1, 2'd0, 2'd0, '0, '0, "R7 zero line frame");
    chk(frame_out[119:110] == 10'b0011111010, "R7 comma neg", {110'd0, frame_out[119:110]}, {110'd0, 10'b0011111010});
    chk(frame_out[109:100] == 10'b0110001011, "R8 D0.0 after comma", {110'd0, frame_out[109:100]}, {110'd0, 10'b0110001011});
    send(2'd1, 2'd3, 2'd3, {24'hFFFFFF, 88'd0}, 32'hFFFF_FFFF, "R10 line ignores extras");
    chk(frame_out[119:110] == 10'b1100000101, "R8 comma pos carried", {110'd0, frame_out[119:110]}, {110'd0, 10'b1100000101});

    // R4/R5: zero history and zero payload leave payload zero
    send(2'd0, 2'd0, 2'd0, '0, 32'hDEAD_BEEF, "R5 zero scramble");
    chk(frame_out == {4'b0101, 84'd0, 32'hDEAD_BEEF}, "R4 protected literal", frame_out, {4'b0101, 84'd0, 32'hDEAD_BEEF});
    send(2'd0, 2'd2, 2'd1, {32'hFFFF_FFFF, 80'h8000_0000_0000_0000_0001}, 32'h1234_5678, "R10 protected ignores high data");
    send(2'd3, 2'd1, 2'd1, rnd112(), 32'h0, "R3 off code");
    send(2'd0, 2'd1, 2'd3, rnd112(), 32'hA5A5_0F0F, "R6 history after off code");
    send(2'd2, 2'd2, 2'd1, {112{1'b1}}, '0, "R9 wide ones");
    send(2'd0, 2'd0, 2'd0, rnd112(), 32'h0, "R6 history across wide");

    // R2: idle cycle holds frame, strobe low
    @(negedge clk);
    chk(frame_valid == 1'b0, "R2 idle strobe", {119'd0, frame_valid}, '0);
    chk(frame_out == m_last, "R2 idle hold", frame_out, m_last);

    // random mix
    for (int n = 0; n < 600; n++) begin
      f = (n % 7 == 0) ? 2'($urandom()) : (n < 300 ? 2'd1 : 2'($urandom_range(0, 2)));
      send(f, 2'($urandom()), 2'($urandom()), rnd112(), $urandom(),
           f == 2'd0 ? "R5 R6 random protected" : f == 2'd1 ? "R7 R8 random line" :
           f == 2'd2 ? "R9 random wide" : "R3 random off");
    end

    // R1/R6/R8: mid-run reset restores zero history and negative disparity
    do_reset();
    chk(frame_valid == 1'b0 && frame_out == '0, "R1 reset mid-run", frame_out, '0);
    send(2'd0, 2'd0, 2'd0, '0, '0, "R6 history reset");
    send(2'd1, 2'd0, 2'd0, {88{1'b1}}, '0, "R8 disparity reset");
    chk(frame_out[119:110] == 10'b0011111010, "R8 comma neg after reset", {110'd0, frame_out[119:110]}, {110'd0, 10'b0011111010});
    summary();
  end
endmodule